// File: doc/BRIEF.md
# Interrupt Core-Map Update Engine

This engine sits beside the routing state of an interrupt router and handles writes to the per-source core-map registers. Each 32-bit map write covers four neighbouring sources, one byte per source. The engine decodes each byte into a target core, using either a one-hot rule or a binary rule chosen by a mode input. It then walks the four sources in order. A source whose target core changes while its raw line is pending is moved with two commands on the command output: a lower to the old core, then a raise to the new core. A source that is not pending only has its stored mapping updated.

A restore write loads saved register contents. It updates all four mappings at once and issues no commands. The raw 32-bit word of every write is kept as written and can be read back through a combinational read port. The decoded per-source core map is brought out as a flat vector for the routing logic that sits next to the engine.

Top module: `cmap_engine`

## Requirements
- R1: After reset, every decoded core is 0, every raw word reads 0, busy_o is low and cmd_valid_o is low.
- R2: In a write to word w, byte k (bits 8k+7..8k) sets the core of source 4w+k, so the least significant byte maps the lowest source.
- R3: With enc_mode_i low, the core is the index of the lowest set bit of the byte. A byte of zero, or a lowest set bit at index N_CORE (4) or above, maps to core 0.
- R4: With enc_mode_i high, the byte value is taken directly as the core number.
- R5: A source whose decoded core equals its current core produces no command.
- R6: A pending source (raw_pend_i bit set) whose core changes produces a lower command (cmd_raise_o=0) to the old core. On the next cycle it produces a raise command (cmd_raise_o=1) to the new core for the same source.
- R7: A source whose core changes but is not pending has only its mapping updated, with no command.
- R8: A write with wr_restore_i high updates all four mappings in the cycle after acceptance, issues no commands and never raises busy_o.
- R9: A normal write raises busy_o in the next cycle. busy_o stays high for 4 cycles plus one extra cycle per migrated source. At most one command appears per cycle, and only while busy_o is high.
- R10: A write presented while busy_o is high is ignored: the raw word and the mappings stay unchanged.
- R11: rd_data_o returns the raw word last accepted at rd_word_i, unchanged.
- R12: The sources of one write are processed in ascending order, so all commands for a lower source come before those for a higher one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Map write strobe |
| wr_restore_i | input | 1 | Restore write: update the map without commands |
| wr_word_i | input | WORD_W | Index of the map word being written |
| wr_data_i | input | 32 | Four core bytes, the lowest byte for the lowest source |
| enc_mode_i | input | 1 | 1: binary core byte, 0: one-hot core byte |
| raw_pend_i | input | N_SRC | Raw pending level per source |
| rd_word_i | input | WORD_W | Raw word read index |
| rd_data_o | output | 32 | Raw word as written |
| core_map_o | output | N_SRC*8 | Decoded core per source, source s at bits 8s+7..8s |
| busy_o | output | 1 | Sequencer processing a write |
| cmd_valid_o | output | 1 | Command valid this cycle |
| cmd_raise_o | output | 1 | 1: raise, 0: lower |
| cmd_src_o | output | SRC_W | Source number of the command |
| cmd_core_o | output | 8 | Core index of the command |

## Verification
The bench checks a one-hot byte whose lowest set bit lies above the core range, and a zero byte. A decoder that took the highest bit, or did not clamp the index, would route these sources to a core that does not exist. It remaps four pending sources at once and checks the exact lower-then-raise pairs in ascending source order. Swapped phases, or a lower sent to the new core, would leave a stale interrupt on the old core. Repeated writes, restore writes and writes injected while busy check that no command is issued where none is due, and that nothing is accepted during processing. A design that re-issued commands, or let a second write overwrite the first mid-flight, would show wrong busy lengths, extra commands or a changed raw word.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
  typedef enum logic {
    PH_CHECK = 1'b0,
    PH_RAISE = 1'b1
  } phase_e;
endpackage

// File: rtl/cmap_decode.sv
module cmap_decode #(
  parameter int N_CORE = 4,
  parameter int CORE_W = 8
) (
  input  logic [CORE_W-1:0] byte_i,
  input  logic              enc_i,
  output logic [CORE_W-1:0] core_o
);
  logic [CORE_W-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = CORE_W - 1; i >= 0; i--) begin
      if (byte_i[i]) low_idx = CORE_W'(i);
    end
  end

  always_comb begin
    if (enc_i) core_o = byte_i;
    else if (byte_i == '0 || int'(low_idx) >= N_CORE) core_o = '0;
    else core_o = low_idx;
  end
endmodule

// File: rtl/cmap_store.sv
module cmap_store #(
  parameter int N_SRC  = 32,
  parameter int CORE_W = 8,
  parameter int LANES  = 4,
  localparam int N_WORD = N_SRC / LANES,
  localparam int WORD_W = $clog2(N_WORD),
  localparam int DATA_W = LANES * CORE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    raw_we_i,
  input  logic [WORD_W-1:0]       raw_word_i,
  input  logic [DATA_W-1:0]       raw_data_i,
  input  logic [WORD_W-1:0]       rd_word_i,
  output logic [DATA_W-1:0]       rd_data_o,
  input  logic [LANES-1:0]        upd_mask_i,
  input  logic [WORD_W-1:0]       upd_word_i,
  input  logic [DATA_W-1:0]       upd_cores_i,
  output logic [N_SRC*CORE_W-1:0] map_o
);
  logic [DATA_W-1:0] raw_q [N_WORD];

  for (genvar w = 0; w < N_WORD; w++) begin : g_raw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_q[w] <= '0;
      else if (raw_we_i && raw_word_i == WORD_W'(w)) raw_q[w] <= raw_data_i;
    end
  end

  assign rd_data_o = raw_q[rd_word_i];

  for (genvar s = 0; s < N_SRC; s++) begin : g_map
    localparam int WI = s / LANES;
    localparam int LI = s % LANES;
    logic [CORE_W-1:0] core_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) core_q <= '0;
      else if (upd_mask_i[LI] && upd_word_i == WORD_W'(WI))
        core_q <= upd_cores_i[LI*CORE_W +: CORE_W];
    end
    assign map_o[s*CORE_W +: CORE_W] = core_q;
  end
endmodule

// File: rtl/cmap_seq.sv
module cmap_seq
  import cmap_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int CORE_W = 8,
  parameter int LANES  = 4,
  localparam int N_WORD = N_SRC / LANES,
  localparam int WORD_W = $clog2(N_WORD),
  localparam int LANE_W = $clog2(LANES),
  localparam int SRC_W  = WORD_W + LANE_W,
  localparam int DATA_W = LANES * CORE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [WORD_W-1:0]       word_i,
  input  logic [DATA_W-1:0]       cores_i,
  input  logic [N_SRC*CORE_W-1:0] map_i,
  input  logic [N_SRC-1:0]        pend_i,
  output logic                    busy_o,
  output logic                    cmd_valid_o,
  output logic                    cmd_raise_o,
  output logic [SRC_W-1:0]        cmd_src_o,
  output logic [CORE_W-1:0]       cmd_core_o,
  output logic [LANES-1:0]        upd_mask_o,
  output logic [WORD_W-1:0]       upd_word_o,
  output logic [DATA_W-1:0]       upd_cores_o
);
  logic              busy_q;
  phase_e            phase_q;
  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] word_q;
  logic [CORE_W-1:0] new_q [LANES];
  logic [CORE_W-1:0] map_a [N_SRC];

  logic [SRC_W-1:0]  src;
  logic [CORE_W-1:0] old_core, new_core;
  logic              changed, step, to_raise;

  for (genvar s = 0; s < N_SRC; s++) begin : g_unpack
    assign map_a[s] = map_i[s*CORE_W +: CORE_W];
  end
  for (genvar l = 0; l < LANES; l++) begin : g_pack
    assign upd_cores_o[l*CORE_W +: CORE_W] = new_q[l];
  end

  assign src      = {word_q, lane_q};
  assign old_core = map_a[src];
  assign new_core = new_q[lane_q];
  assign changed  = old_core != new_core;

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_raise_o = 1'b0;
    cmd_core_o  = old_core;
    upd_mask_o  = '0;
    step        = 1'b0;
    to_raise    = 1'b0;
    if (busy_q) begin
      if (phase_q == PH_RAISE) begin
        cmd_valid_o        = 1'b1;
        cmd_raise_o        = 1'b1;
        cmd_core_o         = new_core;
        upd_mask_o[lane_q] = 1'b1;
        step               = 1'b1;
      end else if (changed && pend_i[src]) begin
        cmd_valid_o = 1'b1;
        to_raise    = 1'b1;
      end else begin
        upd_mask_o[lane_q] = changed;
        step               = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= PH_CHECK;
      lane_q  <= '0;
      word_q  <= '0;
      for (int l = 0; l < LANES; l++) new_q[l] <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        phase_q <= PH_CHECK;
        lane_q  <= '0;
        word_q  <= word_i;
        for (int l = 0; l < LANES; l++) new_q[l] <= cores_i[l*CORE_W +: CORE_W];
      end
    end else if (to_raise) begin
      phase_q <= PH_RAISE;
    end else if (step) begin
      phase_q <= PH_CHECK;
      if (lane_q == LANE_W'(LANES - 1)) busy_q <= 1'b0;
      else lane_q <= lane_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign cmd_src_o  = src;
  assign upd_word_o = word_q;
endmodule

// File: rtl/cmap_engine.sv
module cmap_engine #(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int CORE_W = 8,
  parameter int LANES  = 4,
  localparam int N_WORD = N_SRC / LANES,
  localparam int WORD_W = $clog2(N_WORD),
  localparam int SRC_W  = WORD_W + $clog2(LANES),
  localparam int DATA_W = LANES * CORE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    wr_restore_i,
  input  logic [WORD_W-1:0]       wr_word_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    enc_mode_i,
  input  logic [N_SRC-1:0]        raw_pend_i,
  input  logic [WORD_W-1:0]       rd_word_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [N_SRC*CORE_W-1:0] core_map_o,
  output logic                    busy_o,
  output logic                    cmd_valid_o,
  output logic                    cmd_raise_o,
  output logic [SRC_W-1:0]        cmd_src_o,
  output logic [CORE_W-1:0]       cmd_core_o
);
  logic [DATA_W-1:0] dec_cores;
  logic              accept, restore_upd;
  logic [LANES-1:0]  seq_mask, upd_mask;
  logic [WORD_W-1:0] seq_word, upd_word;
  logic [DATA_W-1:0] seq_cores, upd_cores;

  for (genvar l = 0; l < LANES; l++) begin : g_dec
    cmap_decode #(.N_CORE(N_CORE), .CORE_W(CORE_W)) u_dec (
      .byte_i (wr_data_i[l*CORE_W +: CORE_W]),
      .enc_i  (enc_mode_i),
      .core_o (dec_cores[l*CORE_W +: CORE_W])
    );
  end

  assign accept      = wr_en_i && !busy_o;
  assign restore_upd = accept && wr_restore_i;

  // restore only lands while the sequencer is idle, so the two never collide
  assign upd_mask  = restore_upd ? {LANES{1'b1}} : seq_mask;
  assign upd_word  = restore_upd ? wr_word_i : seq_word;
  assign upd_cores = restore_upd ? dec_cores : seq_cores;

  cmap_store #(.N_SRC(N_SRC), .CORE_W(CORE_W), .LANES(LANES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raw_we_i    (accept),
    .raw_word_i  (wr_word_i),
    .raw_data_i  (wr_data_i),
    .rd_word_i   (rd_word_i),
    .rd_data_o   (rd_data_o),
    .upd_mask_i  (upd_mask),
    .upd_word_i  (upd_word),
    .upd_cores_i (upd_cores),
    .map_o       (core_map_o)
  );

  cmap_seq #(.N_SRC(N_SRC), .CORE_W(CORE_W), .LANES(LANES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept && !wr_restore_i),
    .word_i      (wr_word_i),
    .cores_i     (dec_cores),
    .map_i       (core_map_o),
    .pend_i      (raw_pend_i),
    .busy_o      (busy_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_raise_o (cmd_raise_o),
    .cmd_src_o   (cmd_src_o),
    .cmd_core_o  (cmd_core_o),
    .upd_mask_o  (seq_mask),
    .upd_word_o  (seq_word),
    .upd_cores_o (seq_cores)
  );
endmodule

// File: rtl/cmap_engine_chk.sv
module cmap_engine_chk #(
  parameter int N_SRC  = 32,
  parameter int CORE_W = 8,
  parameter int SRC_W  = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic                    wr_restore_i,
  input logic                    busy_o,
  input logic                    cmd_valid_o,
  input logic                    cmd_raise_o,
  input logic [SRC_W-1:0]        cmd_src_o,
  input logic [CORE_W-1:0]       cmd_core_o,
  input logic [N_SRC*CORE_W-1:0] core_map_o
);
  AST_CMD_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);  // R9

  AST_LOWER_THEN_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_raise_o) |=> (cmd_valid_o && cmd_raise_o && $stable(cmd_src_o)));  // R6

  AST_RAISE_AFTER_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_raise_o) |-> $past(cmd_valid_o && !cmd_raise_o));  // R6

  AST_MOVE_NEW_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_raise_o) |=> (cmd_core_o != $past(cmd_core_o)));  // R5

  AST_RESTORE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_restore_i && !busy_o) |=> (!busy_o && !cmd_valid_o));  // R8

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_restore_i && !busy_o) |=> busy_o);  // R9

  AST_IDLE_MAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !wr_en_i) |=> $stable(core_map_o));  // R10
endmodule

bind cmap_engine cmap_engine_chk #(.N_SRC(N_SRC), .CORE_W(CORE_W), .SRC_W(SRC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_restore_i (wr_restore_i),
  .busy_o       (busy_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_raise_o  (cmd_raise_o),
  .cmd_src_o    (cmd_src_o),
  .cmd_core_o   (cmd_core_o),
  .core_map_o   (core_map_o)
);

// File: tb/cmap_engine_tb.sv
`timescale 1ns/1ps
module cmap_engine_tb;
  localparam int N_SRC = 32;
  localparam int N_WORD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_restore = 1'b0, enc_mode = 1'b0;
  logic [2:0]  wr_word = '0, rd_word = '0;
  logic [31:0] wr_data = '0, raw_pend = '0;
  logic [31:0] rd_data;
  logic [255:0] core_map;
  logic        busy, cmd_valid, cmd_raise;
  logic [4:0]  cmd_src;
  logic [7:0]  cmd_core;

  int checks = 0;
  int failures = 0;
  int exp_map [N_SRC];
  logic [31:0] exp_raw [N_WORD];
  int e_src [8], e_core [8], e_raise [8];

  always #5 clk = ~clk;

  cmap_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_restore_i(wr_restore),
    .wr_word_i(wr_word), .wr_data_i(wr_data), .enc_mode_i(enc_mode),
    .raw_pend_i(raw_pend), .rd_word_i(rd_word), .rd_data_o(rd_data),
    .core_map_o(core_map), .busy_o(busy), .cmd_valid_o(cmd_valid),
    .cmd_raise_o(cmd_raise), .cmd_src_o(cmd_src), .cmd_core_o(cmd_core)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int dec(input logic [7:0] b, input logic enc);
    if (enc) return int'(b);
    for (int i = 0; i < 8; i++) if (b[i]) return (i >= 4) ? 0 : i;
    return 0;
  endfunction

  task automatic check_map(input string req);
    bit ok = 1'b1;
    int bad = 0;
    for (int s = 0; s < N_SRC; s++)
      if (int'(core_map[s*8 +: 8]) != exp_map[s]) begin ok = 1'b0; bad = s; end
    chk(ok, req, int'(core_map[bad*8 +: 8]), exp_map[bad]);
  endtask

  task automatic check_raw(input int w, input string req);
    rd_word = 3'(w);
    #1;
    chk(rd_data == exp_raw[w], req, rd_data, exp_raw[w]);
  endtask

  task automatic do_write(input int w, input logic [31:0] d, input logic enc,
                          input logic rest, input logic [31:0] pend, input bit inject);
    int n_exp = 0, n_cyc = 0, n_cmd = 0, mig = 0;
    for (int k = 0; k < 4; k++) begin
      int s = w * 4 + k;
      int nc = dec(d[k*8 +: 8], enc);
      if (!rest && nc != exp_map[s] && pend[s]) begin
        e_src[n_exp] = s; e_core[n_exp] = exp_map[s]; e_raise[n_exp] = 0; n_exp++;
        e_src[n_exp] = s; e_core[n_exp] = nc;         e_raise[n_exp] = 1; n_exp++;
        mig++;
      end
      exp_map[s] = nc;
    end
    exp_raw[w] = d;
    @(negedge clk);
    raw_pend = pend; wr_word = 3'(w); wr_data = d; enc_mode = enc;
    wr_restore = rest; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (rest) begin
      chk(!busy && !cmd_valid, "R8 restore quiet", {busy, cmd_valid}, 0);
    end else begin
      while (busy && n_cyc < 20) begin
        if (inject && n_cyc == 0) begin
          wr_en = 1'b1; wr_word = 3'((w + 1) % N_WORD); wr_data = ~d; wr_restore = 1'b0;
        end
        if (cmd_valid) begin
          if (n_cmd < n_exp) begin
            chk(int'(cmd_src) == e_src[n_cmd], "R12 cmd source order", cmd_src, e_src[n_cmd]);
            chk(int'(cmd_core) == e_core[n_cmd], "R6 cmd core", cmd_core, e_core[n_cmd]);
            chk(int'(cmd_raise) == e_raise[n_cmd], "R6 cmd lower/raise", cmd_raise, e_raise[n_cmd]);
          end
          n_cmd++;
        end
        n_cyc++;
        @(negedge clk);
        wr_en = 1'b0;
      end
      chk(n_cyc == 4 + mig, "R9 busy length", n_cyc, 4 + mig);
      chk(n_cmd == n_exp, "R5 R7 command count", n_cmd, n_exp);
    end
    check_map("R2 R3 R4 map contents");
    check_raw(w, "R11 raw readback");
    if (inject) check_raw((w + 1) % N_WORD, "R10 busy write ignored");
  endtask

  initial begin
    for (int s = 0; s < N_SRC; s++) exp_map[s] = 0;
    for (int w = 0; w < N_WORD; w++) exp_raw[w] = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !cmd_valid, "R1 reset idle", {busy, cmd_valid}, 0);
    check_map("R1 reset map");
    for (int w = 0; w < N_WORD; w++) check_raw(w, "R1 reset raw");

    do_write(0, 32'h08_04_02_01, 1'b0, 1'b0, 32'h0, 1'b0);          // R3 R7
    do_write(0, 32'h01_02_04_08, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0);  // R6 R12
    do_write(0, 32'h01_02_04_08, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0);  // R5
    do_write(1, 32'h00_10_80_0C, 1'b0, 1'b0, 32'h0000_00F0, 1'b0);  // R3 clamp
    do_write(2, 32'hA5_07_00_13, 1'b1, 1'b0, 32'h0000_0500, 1'b0);  // R4
    do_write(3, 32'h11_22_33_44, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);  // R8
    do_write(5, 32'h02_01_08_04, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1);  // R10

    for (int i = 0; i < 60; i++) begin
      logic [31:0] d;
      logic enc = 1'($urandom_range(0, 3) == 0);
      for (int k = 0; k < 4; k++)
        d[k*8 +: 8] = enc ? 8'($urandom_range(0, 5))
                          : 8'(1 << $urandom_range(0, 8));
      do_write($urandom_range(0, 7), d, enc, 1'($urandom_range(0, 7) == 0),
               $urandom, 1'($urandom_range(0, 5) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule